// File: doc/BRIEF.md
# Interleaved Reed-Solomon Syndrome Bank

This block computes the six syndromes of RS(127,121) codewords over GF(2^7), which corrects up to three symbol errors. Received symbols arrive one per cycle on a valid/ready input. Three syndrome accumulators take turns on whole codewords. Codeword k goes to accumulator k mod 3. While one accumulator waits for a slow downstream key-equation solver to take its result, the next accumulator is already filling.

Each codeword is exactly 127 symbols long, and a running symbol count marks where it starts and ends. When a codeword's last symbol is taken, its accumulator presents all six syndromes on a valid/ready output. The result carries a sequence tag for the codeword and a flag that reports a clean codeword. Results leave in the order their codewords arrived. If the accumulator due to take the next codeword still holds a result that has not been accepted, the input stalls.

Top module: `rs_syn_bank`

## Requirements
- R1: For a codeword r whose first symbol is the coefficient of x^126, the block reports S_j = r(alpha^j) for j = 1..6. The field is GF(2^7) generated by x^7 + x^3 + 1 with alpha = 0x02. S_j sits in syn_o bits [7j-1 : 7j-7].
- R2: Every 127 accepted symbols form one codeword. The next accepted symbol starts a new codeword with its syndromes restarted.
- R3: Codeword k (counted from 0 after reset) is accumulated by unit k mod 3. Results appear on the output in codeword arrival order.
- R4: syn_tag_o equals the codeword's sequence number modulo 256. The first codeword after reset has tag 0.
- R5: syn_no_err_o is 1 exactly when syn_valid_o is 1 and all six syndromes are zero.
- R6: syn_valid_o rises in the cycle after the clock edge that accepts a codeword's last symbol, provided no older result is pending. While syn_ready_i is low, syn_valid_o, syn_o and syn_tag_o hold steady.
- R7: in_ready_o is low while the unit due for the next symbol holds an unaccepted result. A symbol offered while in_ready_o is low is not consumed.
- R8: During and after reset with no input, syn_valid_o is 0 and in_ready_o is 1.
- R9: Idle cycles with in_valid_i low inside a codeword do not change its syndromes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input symbol valid |
| in_sym_i | input | 7 | Received symbol |
| in_ready_o | output | 1 | Input symbol accepted when high together with valid |
| syn_valid_o | output | 1 | Syndrome vector valid |
| syn_ready_i | input | 1 | Downstream accepts the syndrome vector |
| syn_o | output | 42 | Six syndromes, S1 in the low bits |
| syn_tag_o | output | 8 | Codeword sequence tag |
| syn_no_err_o | output | 1 | All six syndromes zero |

## Verification
A symbol is consumed at the rising edge where in_valid_i and in_ready_o are both high. The bench drives every input at the falling edge and reads in_ready_o before that edge. A codeword's result is due right after the edge that takes its 127th symbol, so the latency check samples syn_valid_o one falling edge before that edge and one falling edge after it. Stall and hold checks sample in_ready_o and the held outputs over several falling edges while syn_ready_i is low. The expected syndromes come from a table-based field model that evaluates the received polynomial at each power of alpha directly.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;
  localparam int SYM_W = 7;
  localparam logic [SYM_W:0] GF_POLY = 8'h89;  // x^7 + x^3 + 1

  // multiply x by alpha^p in GF(2^7)
  function automatic logic [SYM_W-1:0] gf_mul_apow(input logic [SYM_W-1:0] x, input int p);
    logic [SYM_W-1:0] v;
    v = x;
    for (int i = 0; i < p; i++) begin
      v = v[SYM_W-1] ? ((v << 1) ^ GF_POLY[SYM_W-1:0]) : (v << 1);
    end
    return v;
  endfunction
endpackage

// File: rtl/rs_syn_unit.sv
module rs_syn_unit
  import rs_syn_pkg::*;
#(
  parameter int NSYN  = 6,
  parameter int TAG_W = 8,
  localparam int SYN_W = NSYN * SYM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             clr_i,
  output logic             done_o,
  output logic [SYN_W-1:0] syn_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             done_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      tag_q  <= '0;
    end else begin
      if (clr_i) done_q <= 1'b0;
      if (we_i && last_i) done_q <= 1'b1;
      if (we_i && first_i) tag_q <= tag_i;
    end
  end

  for (genvar j = 0; j < NSYN; j++) begin : g_syn
    logic [SYM_W-1:0] s_q;
    // Horner step: S_j <- S_j * alpha^j + r
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_q <= '0;
      else if (we_i) s_q <= (first_i ? '0 : gf_mul_apow(s_q, j + 1)) ^ sym_i;
    end
    assign syn_o[j*SYM_W +: SYM_W] = s_q;
  end

  assign done_o = done_q;
  assign tag_o  = tag_q;

  a_r7_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !done_q);
  a_r6_unit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_i) |=> (done_q && $stable(syn_o) && $stable(tag_q)));
endmodule

// File: rtl/rs_syn_bank.sv
module rs_syn_bank
  import rs_syn_pkg::*;
#(
  parameter int N_SYM   = 127,
  parameter int T       = 3,
  parameter int N_UNITS = 3,
  parameter int TAG_W   = 8,
  localparam int NSYN  = 2 * T,
  localparam int SYN_W = NSYN * SYM_W,
  localparam int CNT_W = $clog2(N_SYM),
  localparam int SEL_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [SYM_W-1:0] in_sym_i,
  output logic             in_ready_o,
  output logic             syn_valid_o,
  input  logic             syn_ready_i,
  output logic [SYN_W-1:0] syn_o,
  output logic [TAG_W-1:0] syn_tag_o,
  output logic             syn_no_err_o
);
  logic [CNT_W-1:0] sym_cnt;
  logic [SEL_W-1:0] wr_sel, rd_sel;
  logic [TAG_W-1:0] cw_cnt;
  logic [N_UNITS-1:0] done;
  logic [SYN_W-1:0] syn_arr [N_UNITS];
  logic [TAG_W-1:0] tag_arr [N_UNITS];

  logic fire, first, last, take;

  assign in_ready_o = !done[wr_sel];
  assign fire  = in_valid_i && in_ready_o;
  assign first = (sym_cnt == '0);
  assign last  = (sym_cnt == CNT_W'(N_SYM - 1));
  assign take  = syn_valid_o && syn_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_cnt <= '0;
      wr_sel  <= '0;
      cw_cnt  <= '0;
    end else if (fire) begin
      if (last) begin
        sym_cnt <= '0;
        cw_cnt  <= cw_cnt + 1'b1;
        wr_sel  <= (wr_sel == SEL_W'(N_UNITS - 1)) ? '0 : wr_sel + 1'b1;
      end else begin
        sym_cnt <= sym_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_sel <= '0;
    else if (take) rd_sel <= (rd_sel == SEL_W'(N_UNITS - 1)) ? '0 : rd_sel + 1'b1;
  end

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    rs_syn_unit #(.NSYN(NSYN), .TAG_W(TAG_W)) u_unit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (fire && (wr_sel == SEL_W'(u))),
      .first_i(first),
      .last_i (last),
      .sym_i  (in_sym_i),
      .tag_i  (cw_cnt),
      .clr_i  (take && (rd_sel == SEL_W'(u))),
      .done_o (done[u]),
      .syn_o  (syn_arr[u]),
      .tag_o  (tag_arr[u])
    );
  end

  assign syn_valid_o  = done[rd_sel];
  assign syn_o        = syn_arr[rd_sel];
  assign syn_tag_o    = tag_arr[rd_sel];
  assign syn_no_err_o = syn_valid_o && (syn_o == '0);

  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_cnt <= CNT_W'(N_SYM - 1));
  a_r7_stall_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> syn_valid_o);
  a_r6_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn_valid_o && !syn_ready_i) |=> (syn_valid_o && $stable(syn_o) && $stable(syn_tag_o)));
  a_r5_no_err_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_no_err_o |-> syn_valid_o);
endmodule

// File: tb/rs_syn_bank_tb.sv
module rs_syn_bank_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [6:0] in_sym = '0;
  logic in_ready, syn_valid, no_err;
  logic syn_ready = 1'b0;
  logic [41:0] syn;
  logic [7:0] tag;

  int n_chk = 0, n_fail = 0;
  int gexp [0:126];
  int glog [0:127];
  int cw [0:126];
  logic [41:0] exp_syn [0:7];
  int next_tag = 0;

  always #4 clk = ~clk;

  rs_syn_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_sym_i(in_sym),
    .in_ready_o(in_ready), .syn_valid_o(syn_valid), .syn_ready_i(syn_ready),
    .syn_o(syn), .syn_tag_o(tag), .syn_no_err_o(no_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 127];
  endfunction

  function automatic logic [41:0] model_syn();
    logic [41:0] r = '0;
    for (int j = 1; j <= 6; j++) begin
      int s = 0;
      for (int i = 0; i < 127; i++) s ^= gmul(cw[i], gexp[(j * (126 - i)) % 127]);
      r[(j-1)*7 +: 7] = 7'(s);
    end
    return r;
  endfunction

  // systematic encoding into cw: 121 data then 6 parity
  task automatic make_cw(input bit zero);
    int g [0:6];
    int rem [0:5];
    for (int k = 0; k < 7; k++) g[k] = 0;
    g[0] = 1;
    for (int j = 1; j <= 6; j++) begin
      for (int k = 6; k >= 1; k--) g[k] = g[k-1] ^ gmul(g[k], gexp[j]);
      g[0] = gmul(g[0], gexp[j]);
    end
    for (int k = 0; k < 6; k++) rem[k] = 0;
    for (int i = 0; i < 121; i++) begin
      int fb;
      cw[i] = zero ? 0 : int'($urandom_range(0, 127));
      fb = cw[i] ^ rem[5];
      for (int k = 5; k >= 1; k--) rem[k] = rem[k-1] ^ gmul(fb, g[k]);
      rem[0] = gmul(fb, g[0]);
    end
    for (int k = 0; k < 6; k++) cw[121 + k] = rem[5 - k];
  endtask

  task automatic add_errors(input int n);
    for (int e = 0; e < n; e++) cw[$urandom_range(0, 126)] ^= int'($urandom_range(1, 127));
  endtask

  task automatic send_cw(input int gap);
    for (int i = 0; i < 127; i++) begin
      int w = 0;
      @(negedge clk);
      in_valid = 1'b1;
      in_sym = 7'(cw[i]);
      while (!in_ready && w < 2000) begin
        @(negedge clk);
        w++;
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_sym = 7'h2a;
      for (int k = 0; k < gap; k++) @(negedge clk);
    end
  endtask

  task automatic read_res(input logic [41:0] e, input string req);
    int w = 0;
    @(negedge clk);
    while (!syn_valid && w < 1000) begin
      @(negedge clk);
      w++;
    end
    chk(syn == e, {req, " syndromes"}, 64'(syn), 64'(e));
    chk(tag == 8'(next_tag), "R4 tag", 64'(tag), 64'(next_tag));
    chk(no_err == (e == '0), "R5 no_err", 64'(no_err), 64'(e == '0));
    next_tag++;
    syn_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    syn_ready = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk(syn_valid == 1'b0, "R8 valid in reset", 64'(syn_valid), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(syn_valid == 1'b0, "R8 valid after reset", 64'(syn_valid), 0);
    chk(in_ready == 1'b1, "R8 ready after reset", 64'(in_ready), 1);
  endtask

  // clean codeword with latency check on the last symbol
  task automatic t_clean_latency;
    make_cw(1'b0);
    exp_syn[0] = model_syn();
    for (int i = 0; i < 126; i++) begin
      @(negedge clk); in_valid = 1'b1; in_sym = 7'(cw[i]); @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b1; in_sym = 7'(cw[126]);
    chk(syn_valid == 1'b0, "R6 not valid before last", 64'(syn_valid), 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(syn_valid == 1'b1, "R6 valid after last", 64'(syn_valid), 1);
    read_res(exp_syn[0], "R1 clean");
  endtask

  task automatic t_errors;
    for (int n = 1; n <= 3; n++) begin
      make_cw(1'b0);
      add_errors(n);
      exp_syn[0] = model_syn();
      send_cw(0);
      read_res(exp_syn[0], "R1 errors");
    end
    make_cw(1'b1);
    exp_syn[0] = model_syn();
    send_cw(0);
    read_res(exp_syn[0], "R2 zero codeword");
  endtask

  task automatic t_gaps;
    make_cw(1'b0);
    add_errors(2);
    exp_syn[0] = model_syn();
    send_cw(2);
    read_res(exp_syn[0], "R9 gaps");
  endtask

  // fill all three units, stall a fourth, check hold and order
  task automatic t_stall_order;
    logic [41:0] held;
    logic [7:0] held_tag;
    for (int c = 0; c < 3; c++) begin
      make_cw(c == 1);
      if (c != 1) add_errors(c + 1);
      exp_syn[c] = model_syn();
      send_cw(0);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_sym = 7'h55;
    held = syn;
    held_tag = tag;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R7 stall while full", 64'(in_ready), 0);
      chk(syn == held && tag == held_tag && syn_valid, "R6 hold", 64'(syn), 64'(held));
    end
    in_valid = 1'b0;
    read_res(exp_syn[0], "R3 first in order");
    chk(in_ready == 1'b1, "R7 ready after accept", 64'(in_ready), 1);
    make_cw(1'b0);
    add_errors(3);
    exp_syn[3] = model_syn();
    send_cw(0);
    read_res(exp_syn[1], "R3 second in order");
    read_res(exp_syn[2], "R3 third in order");
    read_res(exp_syn[3], "R7 stalled symbol not consumed");
  endtask

  initial begin
    int v = 1;
    for (int i = 0; i < 127; i++) begin
      gexp[i] = v;
      glog[v] = i;
      v = v << 1;
      if ((v & 128) != 0) v ^= 137;
    end
    void'($urandom(7));
    t_reset();
    t_clean_latency();
    t_errors();
    t_gaps();
    t_stall_order();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule